// File: doc/BRIEF.md
# Undefined-Instruction Trap Classifier and Stack Frame Writer

This block sits behind the instruction decoder. It receives a fetched 16-bit opcode together with a handful of decoder flags, and decides which undefined-instruction trap, if any, the opcode raises. The candidates are four: an opcode with 0xF in its top nibble that is a floating-point instruction while the floating-point unit is switched off, a floating-point instruction that the hardware does not implement, any other 0xF-nibble opcode that is neither a floating-point nor a known system instruction, and the illegal-instruction trap. The illegal trap has several sources of its own, among them the termination of a breakpoint-acknowledge bus cycle.

The three 0xF-nibble causes share one vector but differ in three ways: the frame format, the stacked program counter, and the extra words they stack. Once a cause is chosen, the block holds the vector number, the format code and the stacked PC on its outputs. It then writes the exception frame as 16-bit words on a simple write port, starting at the highest address, and signals completion with a one-cycle done pulse.

Top module: `undef_trap_framer`

## Requirements
- R1: An opcode with bits 15:12 equal to 0xF that has fpInsn set, sysInsn clear and fpuEnable low gives vecNum 11, frameFmt 4 and stackedPc equal to nextPc.
- R2: A format-4 frame holds the operand address in the words at final SP+8 (high half) and SP+10 (low half), and curPc at SP+12 (high) and SP+14 (low). The operand-address field is 0 when memOperand is low.
- R3: When eaMode is 4 (pre-decrement) and opSize is 2 (extended precision), the operand-address field is eaIn+8. For every other mode or size it is eaIn.
- R4: A 0xF-nibble opcode with fpInsn set, fpuEnable high and fpUnimpl set gives vecNum 11, frameFmt 2 and stackedPc equal to nextPc. Its two extra words hold curPc, high half at SP+8.
- R5: A 0xF-nibble opcode with both fpInsn and sysInsn clear gives vecNum 11, frameFmt 0 and stackedPc equal to curPc.
- R6: The opcode 0x4AFC, or movecInsn set with ctrlRegKnown clear, or a non-0xF opcode with otherUndef set, gives vecNum 4, frameFmt 0 and stackedPc equal to curPc.
- R7: bkptCycle high together with xferAck or xferErr raises the illegal trap (vecNum 4, frameFmt 0, stackedPc curPc). This takes priority over any opcode request in the same cycle.
- R8: The 0x4AFC and control-register-field checks take priority over the 0xF-nibble classification.
- R9: Frames have 4, 6 or 8 words for formats 0, 2 and 4. The k-th accepted write (k from 0) goes to spIn-2(k+1). Counting from the final SP upward, the words are SR, PC high, PC low, then {format in 15:12, vector×4 in 11:0}, followed by the extra words.
- R10: While wrEn is high and wrReady is low, wrAddr and wrData hold and no word is consumed.
- R11: done is high for exactly the one cycle after the last accepted write. Requests that arrive while busy are ignored and leave the outputs and the frame unchanged.
- R12: A request that raises no trap writes nothing and leaves vecNum, frameFmt and stackedPc unchanged. Examples are an opcode with sysInsn set, or an implemented floating-point opcode with the unit enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Classify the presented opcode this cycle |
| opWord | input | 16 | Fetched opcode |
| fpInsn | input | 1 | Decoder: opcode is a floating-point instruction |
| sysInsn | input | 1 | Decoder: opcode is a recognised 0xF-nibble system instruction |
| movecInsn | input | 1 | Decoder: opcode is a control-register move |
| ctrlRegKnown | input | 1 | Decoder: control-register field is defined |
| otherUndef | input | 1 | Decoder: non-0xF opcode is unimplemented |
| fpUnimpl | input | 1 | Floating-point instruction not implemented in hardware |
| fpuEnable | input | 1 | Floating-point unit enabled |
| bkptCycle | input | 1 | Breakpoint-acknowledge bus cycle active |
| xferAck | input | 1 | Transfer acknowledge |
| xferErr | input | 1 | Transfer error acknowledge |
| srIn | input | 16 | Status register to stack |
| spIn | input | 32 | Stack pointer before the frame |
| curPc | input | 32 | Address of the offending opcode |
| nextPc | input | 32 | Address of the following instruction |
| eaIn | input | 32 | Computed first-operand address |
| eaMode | input | 3 | Addressing mode, 4 = pre-decrement |
| opSize | input | 3 | Operand size code, 2 = extended |
| memOperand | input | 1 | Operand resides in memory |
| wrReady | input | 1 | Write port accepts a word |
| vecNum | output | 8 | Vector number of the last trap |
| frameFmt | output | 4 | Frame format of the last trap |
| stackedPc | output | 32 | PC placed in the frame |
| wrEn | output | 1 | Word write valid |
| wrAddr | output | 32 | Word write address |
| wrData | output | 16 | Word write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame completion pulse |

## Verification
A breakpoint-acknowledge termination and an opcode request can arrive in the same cycle. A directed case raises both together with a 0xF-nibble floating-point opcode and the unit disabled, and it passes only if the frame comes out as a format-0 illegal frame carrying curPc. A second collision is a new request that arrives while a frame is being written. Random cases keep pulsing reqValid throughout the write stream, and each captured frame and the held vector, format and PC are compared against the bench model of the first request.

// File: rtl/undef_trap_pkg.sv
package undef_trap_pkg;
  localparam int MAX_WORDS = 8;
  localparam int SLOT_W = $clog2(MAX_WORDS);

  typedef enum logic [2:0] {
    CAUSE_NONE,
    CAUSE_ILLEGAL,
    CAUSE_LINEF,
    CAUSE_FPUNIMP,
    CAUSE_FPOFF
  } cause_e;

  typedef struct packed {
    logic       load;
    logic       step;
    logic [3:0] fmt;
    logic [7:0] vec;
    logic       useNext;
  } ctlStrobe_t;
endpackage

// File: rtl/undef_trap_ctl.sv
module undef_trap_ctl
  import undef_trap_pkg::*;
#(
  parameter logic [7:0]  VEC_SHARED = 8'd11,
  parameter logic [7:0]  VEC_ILL    = 8'd4,
  parameter logic [15:0] OP_ILLEGAL = 16'h4AFC
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [15:0] opWord,
  input  logic        fpInsn,
  input  logic        sysInsn,
  input  logic        movecInsn,
  input  logic        ctrlRegKnown,
  input  logic        otherUndef,
  input  logic        fpUnimpl,
  input  logic        fpuEnable,
  input  logic        bkptCycle,
  input  logic        xferAck,
  input  logic        xferErr,
  input  logic        wrReady,
  input  logic        lastWord,
  output ctlStrobe_t  strb,
  output logic        wrEn,
  output logic        busy,
  output logic        done
);
  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_FIN} state_e;
  state_e state;
  cause_e cause;
  logic bkptEnd;

  assign bkptEnd = bkptCycle && (xferAck || xferErr);

  // Priority: breakpoint end, then fixed-opcode / control-field checks, then 0xF nibble.
  always_comb begin
    cause = CAUSE_NONE;
    if (bkptEnd) begin
      cause = CAUSE_ILLEGAL;
    end else if (reqValid) begin
      if (opWord == OP_ILLEGAL || (movecInsn && !ctrlRegKnown)) begin
        cause = CAUSE_ILLEGAL;
      end else if (opWord[15:12] == 4'hF) begin
        if (sysInsn)          cause = CAUSE_NONE;
        else if (!fpInsn)     cause = CAUSE_LINEF;
        else if (!fpuEnable)  cause = CAUSE_FPOFF;
        else if (fpUnimpl)    cause = CAUSE_FPUNIMP;
      end else if (otherUndef) begin
        cause = CAUSE_ILLEGAL;
      end
    end
  end

  always_comb begin
    strb.load    = (state == ST_IDLE) && (cause != CAUSE_NONE);
    strb.step    = (state == ST_WRITE) && wrReady;
    strb.vec     = (cause == CAUSE_ILLEGAL) ? VEC_ILL : VEC_SHARED;
    strb.useNext = (cause == CAUSE_FPOFF) || (cause == CAUSE_FPUNIMP);
    unique case (cause)
      CAUSE_FPOFF:   strb.fmt = 4'd4;
      CAUSE_FPUNIMP: strb.fmt = 4'd2;
      default:       strb.fmt = 4'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  if (strb.load) state <= ST_WRITE;
        ST_WRITE: if (wrReady && lastWord) state <= ST_FIN;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign wrEn = (state == ST_WRITE);
  assign done = (state == ST_FIN);
  assign busy = (state != ST_IDLE);

  p_done_after_last_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(wrEn && wrReady && lastWord));
  p_no_early_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (wrEn || done));
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !wrEn);
endmodule

// File: rtl/undef_trap_dp.sv
module undef_trap_dp
  import undef_trap_pkg::*;
#(
  parameter logic [7:0] VEC_SHARED = 8'd11,
  parameter logic [2:0] MODE_PREDEC = 3'd4,
  parameter logic [2:0] SIZE_EXT = 3'd2
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobe_t  strb,
  input  logic [15:0] srIn,
  input  logic [31:0] spIn,
  input  logic [31:0] curPc,
  input  logic [31:0] nextPc,
  input  logic [31:0] eaIn,
  input  logic [2:0]  eaMode,
  input  logic [2:0]  opSize,
  input  logic        memOperand,
  output logic [7:0]  vecNum,
  output logic [3:0]  frameFmt,
  output logic [31:0] stackedPc,
  output logic [31:0] wrAddr,
  output logic [15:0] wrData,
  output logic        lastWord
);
  logic [15:0] frameWords [MAX_WORDS];
  logic [15:0] newWords   [MAX_WORDS];
  logic [SLOT_W-1:0] slotIdx;
  logic [SLOT_W-1:0] topSlot;
  logic [31:0] eaField;
  logic [31:0] pcPick;

  always_comb begin
    if (!memOperand)                                    eaField = '0;
    else if (eaMode == MODE_PREDEC && opSize == SIZE_EXT) eaField = eaIn + 32'd8;
    else                                                eaField = eaIn;
  end

  assign pcPick = strb.useNext ? nextPc : curPc;

  always_comb begin
    newWords[0] = srIn;
    newWords[1] = pcPick[31:16];
    newWords[2] = pcPick[15:0];
    newWords[3] = {strb.fmt, 2'b00, strb.vec, 2'b00};
    newWords[4] = (strb.fmt == 4'd4) ? eaField[31:16] : curPc[31:16];
    newWords[5] = (strb.fmt == 4'd4) ? eaField[15:0]  : curPc[15:0];
    newWords[6] = curPc[31:16];
    newWords[7] = curPc[15:0];
    unique case (strb.fmt)
      4'd4:    topSlot = SLOT_W'(7);
      4'd2:    topSlot = SLOT_W'(5);
      default: topSlot = SLOT_W'(3);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MAX_WORDS; i++) frameWords[i] <= '0;
      slotIdx   <= '0;
      wrAddr    <= '0;
      vecNum    <= '0;
      frameFmt  <= '0;
      stackedPc <= '0;
    end else if (strb.load) begin
      for (int i = 0; i < MAX_WORDS; i++) frameWords[i] <= newWords[i];
      slotIdx   <= topSlot;
      wrAddr    <= spIn - 32'd2;
      vecNum    <= strb.vec;
      frameFmt  <= strb.fmt;
      stackedPc <= pcPick;
    end else if (strb.step) begin
      slotIdx <= slotIdx - 1'b1;
      wrAddr  <= wrAddr - 32'd2;
    end
  end

  assign wrData   = frameWords[slotIdx];
  assign lastWord = (slotIdx == '0);

  p_addr_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> (wrAddr == $past(wrAddr) - 32'd2));
  p_shared_vec_r1: assert property (@(posedge clk) disable iff (!rstN)
    (frameFmt != 4'd0) |-> (vecNum == VEC_SHARED));
endmodule

// File: rtl/undef_trap_framer.sv
module undef_trap_framer
  import undef_trap_pkg::*;
#(
  parameter logic [7:0]  VEC_SHARED = 8'd11,
  parameter logic [7:0]  VEC_ILL    = 8'd4,
  parameter logic [15:0] OP_ILLEGAL = 16'h4AFC
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [15:0] opWord,
  input  logic        fpInsn,
  input  logic        sysInsn,
  input  logic        movecInsn,
  input  logic        ctrlRegKnown,
  input  logic        otherUndef,
  input  logic        fpUnimpl,
  input  logic        fpuEnable,
  input  logic        bkptCycle,
  input  logic        xferAck,
  input  logic        xferErr,
  input  logic [15:0] srIn,
  input  logic [31:0] spIn,
  input  logic [31:0] curPc,
  input  logic [31:0] nextPc,
  input  logic [31:0] eaIn,
  input  logic [2:0]  eaMode,
  input  logic [2:0]  opSize,
  input  logic        memOperand,
  input  logic        wrReady,
  output logic [7:0]  vecNum,
  output logic [3:0]  frameFmt,
  output logic [31:0] stackedPc,
  output logic        wrEn,
  output logic [31:0] wrAddr,
  output logic [15:0] wrData,
  output logic        busy,
  output logic        done
);
  ctlStrobe_t strb;
  logic lastWord;

  undef_trap_ctl #(.VEC_SHARED(VEC_SHARED), .VEC_ILL(VEC_ILL), .OP_ILLEGAL(OP_ILLEGAL)) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opWord(opWord),
    .fpInsn(fpInsn), .sysInsn(sysInsn), .movecInsn(movecInsn),
    .ctrlRegKnown(ctrlRegKnown), .otherUndef(otherUndef), .fpUnimpl(fpUnimpl),
    .fpuEnable(fpuEnable), .bkptCycle(bkptCycle), .xferAck(xferAck),
    .xferErr(xferErr), .wrReady(wrReady), .lastWord(lastWord),
    .strb(strb), .wrEn(wrEn), .busy(busy), .done(done)
  );

  undef_trap_dp #(.VEC_SHARED(VEC_SHARED)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .srIn(srIn), .spIn(spIn),
    .curPc(curPc), .nextPc(nextPc), .eaIn(eaIn), .eaMode(eaMode),
    .opSize(opSize), .memOperand(memOperand), .vecNum(vecNum),
    .frameFmt(frameFmt), .stackedPc(stackedPc), .wrAddr(wrAddr),
    .wrData(wrData), .lastWord(lastWord)
  );

  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrReady) |=> (wrEn && $stable(wrAddr) && $stable(wrData)));
  p_busy_keeps_vec_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(vecNum) && $stable(frameFmt) && $stable(stackedPc)));
endmodule

// File: tb/sim_undef_trap_framer.sv
`timescale 1ns/1ps
module sim_undef_trap_framer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, fpInsn = 0, sysInsn = 0, movecInsn = 0, ctrlRegKnown = 1;
  logic otherUndef = 0, fpUnimpl = 0, fpuEnable = 1, bkptCycle = 0, xferAck = 0, xferErr = 0;
  logic [15:0] opWord = 16'h0000, srIn = 16'h2700;
  logic [31:0] spIn = 32'h1000, curPc = 0, nextPc = 0, eaIn = 0;
  logic [2:0] eaMode = 0, opSize = 0;
  logic memOperand = 0, wrReady = 0;
  logic [7:0] vecNum;
  logic [3:0] frameFmt;
  logic [31:0] stackedPc, wrAddr;
  logic wrEn, busy, done;
  logic [15:0] wrData;

  int total = 0, bad = 0;
  int expCause, expN;
  logic [7:0] expVec;
  logic [3:0] expFmt;
  logic [31:0] expPc;
  logic [15:0] expW [8];
  logic [31:0] capA [16];
  logic [15:0] capD [16];
  int capN;

  always #5 clk = ~clk;

  undef_trap_framer u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opWord(opWord), .fpInsn(fpInsn),
    .sysInsn(sysInsn), .movecInsn(movecInsn), .ctrlRegKnown(ctrlRegKnown),
    .otherUndef(otherUndef), .fpUnimpl(fpUnimpl), .fpuEnable(fpuEnable),
    .bkptCycle(bkptCycle), .xferAck(xferAck), .xferErr(xferErr), .srIn(srIn),
    .spIn(spIn), .curPc(curPc), .nextPc(nextPc), .eaIn(eaIn), .eaMode(eaMode),
    .opSize(opSize), .memOperand(memOperand), .wrReady(wrReady), .vecNum(vecNum),
    .frameFmt(frameFmt), .stackedPc(stackedPc), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // 0 none, 1 illegal, 2 unimplemented 0xF, 3 fp unimplemented, 4 fp disabled
  function automatic int model();
    if (bkptCycle && (xferAck || xferErr)) return 1;
    if (!reqValid) return 0;
    if (opWord == 16'h4AFC) return 1;
    if (movecInsn && !ctrlRegKnown) return 1;
    if (opWord[15:12] == 4'hF) begin
      if (sysInsn) return 0;
      if (!fpInsn) return 2;
      if (!fpuEnable) return 4;
      if (fpUnimpl) return 3;
      return 0;
    end
    return otherUndef ? 1 : 0;
  endfunction

  function automatic void buildExp(input int c);
    logic [31:0] ea;
    expVec = (c == 1) ? 8'd4 : 8'd11;
    expFmt = (c == 4) ? 4'd4 : (c == 3) ? 4'd2 : 4'd0;
    expPc  = (c == 3 || c == 4) ? nextPc : curPc;
    expN   = (c == 4) ? 8 : (c == 3) ? 6 : 4;
    ea = !memOperand ? 32'd0 : (eaMode == 3'd4 && opSize == 3'd2) ? eaIn + 32'd8 : eaIn;
    expW[0] = srIn;
    expW[1] = expPc[31:16];
    expW[2] = expPc[15:0];
    expW[3] = {expFmt, 2'b00, expVec, 2'b00};
    expW[4] = (c == 4) ? ea[31:16] : curPc[31:16];
    expW[5] = (c == 4) ? ea[15:0]  : curPc[15:0];
    expW[6] = curPc[31:16];
    expW[7] = curPc[15:0];
  endfunction

  function automatic string reqTag(input int c);
    case (c)
      1: return "R6/R7/R8 illegal";
      2: return "R5 unimplemented 0xF";
      3: return "R4 fp unimplemented";
      4: return "R1/R2/R3 fp disabled";
      default: return "R12 no trap";
    endcase
  endfunction

  task automatic clearIn();
    reqValid = 0; bkptCycle = 0; xferAck = 0; xferErr = 0;
  endtask

  // Called at a negedge with stimulus already applied.
  task automatic runCase(input bit noisy);
    logic [7:0] pv; logic [3:0] pf; logic [31:0] pp;
    int guard;
    pv = vecNum; pf = frameFmt; pp = stackedPc;
    expCause = model();
    if (expCause != 0) buildExp(expCause);
    wrReady = 1'b0;
    @(negedge clk);
    clearIn();
    if (expCause == 0) begin
      for (int i = 0; i < 3; i++) begin
        chk(!wrEn && !busy, "R12 no write", {31'd0, wrEn}, 32'd0);
        @(negedge clk);
      end
      chk(vecNum == pv && frameFmt == pf && stackedPc == pp, "R12 outputs kept",
          {vecNum, 20'd0, frameFmt}, {pv, 20'd0, pf});
      return;
    end
    chk(vecNum == expVec, {reqTag(expCause), " vector"}, {24'd0, vecNum}, {24'd0, expVec});
    chk(frameFmt == expFmt, {reqTag(expCause), " format"}, {28'd0, frameFmt}, {28'd0, expFmt});
    chk(stackedPc == expPc, {reqTag(expCause), " pc"}, stackedPc, expPc);
    capN = 0; guard = 0;
    while (!done && guard < 300) begin
      wrReady = ($urandom % 10) < 7;
      if (noisy) begin
        reqValid = $urandom % 2; opWord = 16'h4AFC; bkptCycle = $urandom % 2; xferAck = 1;
      end
      if (wrEn && wrReady && capN < 16) begin
        capA[capN] = wrAddr; capD[capN] = wrData; capN++;
      end
      @(negedge clk);
      guard++;
    end
    clearIn();
    wrReady = 1'b0;
    chk(capN == expN, "R9 word count", capN, expN);
    for (int k = 0; k < expN && k < capN; k++) begin
      chk(capA[k] == spIn - 32'(2 * (k + 1)), "R9 address", capA[k], spIn - 32'(2 * (k + 1)));
      chk(capD[k] == expW[expN - 1 - k], {reqTag(expCause), " R9 frame word"},
          {16'd0, capD[k]}, {16'd0, expW[expN - 1 - k]});
    end
    chk(vecNum == expVec && stackedPc == expPc, "R11 outputs held while busy",
        stackedPc, expPc);
    @(negedge clk);
    chk(!done && !busy, "R11 done one cycle", {30'd0, done, busy}, 32'd0);
  endtask

  task automatic setOp(input logic [15:0] op);
    reqValid = 1; opWord = op; fpInsn = 0; sysInsn = 0; movecInsn = 0; ctrlRegKnown = 1;
    otherUndef = 0; fpUnimpl = 0; fpuEnable = 1; bkptCycle = 0; xferAck = 0; xferErr = 0;
    memOperand = 0; eaMode = 0; opSize = 0;
    curPc = $urandom; nextPc = curPc + 32'd4; eaIn = $urandom; srIn = $urandom;
    spIn = {$urandom % 32'h10000, 1'b0} + 32'h100;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!wrEn && !busy && !done && vecNum == 0, "reset state R11", {29'd0, wrEn, busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2: register operand gives zero EA field
    setOp(16'hF200); fpInsn = 1; fpuEnable = 0; memOperand = 0; runCase(0);
    // R3: pre-decrement extended
    setOp(16'hF220); fpInsn = 1; fpuEnable = 0; memOperand = 1; eaMode = 3'd4; opSize = 3'd2; runCase(0);
    // R3: pre-decrement long keeps eaIn
    setOp(16'hF220); fpInsn = 1; fpuEnable = 0; memOperand = 1; eaMode = 3'd4; opSize = 3'd0; runCase(0);
    // R3: post-increment extended keeps eaIn
    setOp(16'hF218); fpInsn = 1; fpuEnable = 0; memOperand = 1; eaMode = 3'd3; opSize = 3'd2; runCase(0);
    // R4
    setOp(16'hF200); fpInsn = 1; fpUnimpl = 1; runCase(0);
    // R5
    setOp(16'hF548); runCase(0);
    // R6 fixed opcode, control field, other undefined
    setOp(16'h4AFC); runCase(0);
    setOp(16'h4E7B); movecInsn = 1; ctrlRegKnown = 0; runCase(0);
    setOp(16'h0A3C); otherUndef = 1; runCase(0);
    // R7: breakpoint end beats a disabled-fp opcode in the same cycle
    setOp(16'hF200); fpInsn = 1; fpuEnable = 0; bkptCycle = 1; xferErr = 1; runCase(0);
    setOp(16'h0000); reqValid = 0; bkptCycle = 1; xferAck = 1; runCase(0);
    // R8: control field check beats 0xF classification
    setOp(16'hF200); fpInsn = 1; fpuEnable = 0; movecInsn = 1; ctrlRegKnown = 0; runCase(0);
    // R12: system instruction and implemented fp
    setOp(16'hF500); sysInsn = 1; runCase(0);
    setOp(16'hF200); fpInsn = 1; runCase(0);
    // R10/R11: random stalls and requests during writes
    for (int n = 0; n < 60; n++) begin
      int cls;
      cls = $urandom % 8;
      setOp(16'h1234);
      case (cls)
        0: opWord = 16'h4AFC;
        1: begin opWord = 16'h4E7A; movecInsn = 1; ctrlRegKnown = $urandom % 2; end
        2: begin opWord = {4'hF, 12'($urandom)}; fpuEnable = $urandom % 2; end
        3: begin opWord = {4'hF, 12'($urandom)}; fpInsn = 1; fpuEnable = 0; memOperand = $urandom % 2;
                 eaMode = 3'($urandom); opSize = 3'($urandom); end
        4: begin opWord = {4'hF, 12'($urandom)}; fpInsn = 1; fpUnimpl = 1; end
        5: begin opWord = {4'hF, 12'($urandom)}; sysInsn = 1; end
        6: begin opWord = {4'h0, 12'($urandom)}; otherUndef = 1; end
        default: begin reqValid = $urandom % 2; bkptCycle = 1; xferAck = $urandom % 2; xferErr = !xferAck; end
      endcase
      runCase(1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule